// File: doc/BRIEF.md
# DDR SDRAM Command Legality Checker

This block listens to the command pins of a DDR SDRAM interface without driving anything back. In every clock cycle it turns chip select, the three strobe pins, the bank select and the address into one command. It keeps a model of the device state and raises a one-cycle error pulse with a 3-bit reason code when the command breaks a sequencing rule. The model holds, for each bank, whether a row is open and which row it is. It also holds the mode-register settling window and the delay-locked-loop (DLL) state together with its relock window.

The checker is placed beside a memory controller in simulation or in silicon debug logic. A flagged command does not change the tracked state: the model goes on as though the device had refused the command. Command encodings use chip select low (`cs_n`=0) and `{ras_n,cas_n,we_n}` as follows: 111 NOP, 110 burst stop (handled like NOP), 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 LOAD MODE. `cs_n`=1 is DESELECT whatever the other pins hold.

Top module: `ddr_cmd_checker`

## Requirements
- R1: DESELECT, NOP and burst stop never raise an error and never change bank, mode-window or DLL state.
- R2: LOAD MODE while any bank has an open row gives error code 1 and is ignored.
- R3: For MRD_CYCLES-1 cycles after an accepted LOAD MODE, any command other than DESELECT, NOP or burst stop gives code 2 and is ignored. Code 2 takes priority over every other code.
- R4: An accepted LOAD MODE with `ba`=01 sets the DLL state from `addr[0]` (0 = enabled, 1 = disabled). `ba`=00 or any other bank value leaves the DLL state unchanged. `addr[1]` (drive strength) has no effect on checking.
- R5: When an accepted LOAD MODE changes the DLL from disabled to enabled, a READ in the following LOCK_CYCLES-1 cycles gives code 3. A READ exactly LOCK_CYCLES cycles later is legal. A READ while the DLL is disabled is not flagged. Code 3 takes priority over code 5.
- R6: An accepted ACTIVE opens the row on `addr` in bank `ba`. ACTIVE to a bank whose row is already open gives code 4 and is ignored.
- R7: PRECHARGE with `addr[10]`=1 closes every bank. With `addr[10]`=0 it closes only bank `ba`. Precharging an idle bank is legal.
- R8: READ or WRITE to a bank with no open row gives code 5.
- R9: REFRESH while any bank has an open row gives code 6. REFRESH with all banks idle is legal.
- R10: After reset all banks are idle, the DLL is disabled and no window is running. `err_valid` rises in the cycle after the offending command is sampled and stays high for one cycle per offending command. `err_code` is 0 whenever `err_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank select |
| addr | input | ADDR_W (13) | Row / mode / precharge-all address |
| err_valid | output | 1 | One-cycle rule-violation pulse |
| err_code | output | 3 | Reason code, 0 when no error |

## Verification
Every result, whether an error pulse or its absence, is due exactly one clock edge after the command is sampled, because the only register on the path is the output flop. The driver applies a command after a falling edge and pushes one expected code for that cycle. The monitor pops it 2 ns after the next rising edge, so each queued item pairs with exactly one command. The window edges are checked by counting issued cycles from the LOAD MODE: one illegal command inside the mode window, then legal commands right after it, and READs at LOCK_CYCLES-1 and at LOCK_CYCLES cycles after the DLL is enabled. Ignored commands are shown to have had no effect through later commands whose outcome depends on the bank state.

// File: rtl/ddr_chk_pkg.sv
`timescale 1ns/1ps
package ddr_chk_pkg;

   typedef enum logic [2:0] {
      CMD_DESEL = 3'd0,
      CMD_NOP   = 3'd1,
      CMD_ACT   = 3'd2,
      CMD_RD    = 3'd3,
      CMD_WR    = 3'd4,
      CMD_PRE   = 3'd5,
      CMD_REF   = 3'd6,
      CMD_LMR   = 3'd7
   } cmd_e;

   localparam logic [2:0] ERR_NONE     = 3'd0;
   localparam logic [2:0] ERR_LMR_OPEN = 3'd1;
   localparam logic [2:0] ERR_MRD_WIN  = 3'd2;
   localparam logic [2:0] ERR_DLL_LOCK = 3'd3;
   localparam logic [2:0] ERR_ACT_OPEN = 3'd4;
   localparam logic [2:0] ERR_IDLE_ACC = 3'd5;
   localparam logic [2:0] ERR_REF_OPEN = 3'd6;

endpackage

// File: rtl/ddr_chk_decode.sv
`timescale 1ns/1ps
module ddr_chk_decode
   import ddr_chk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b111:  cmd = CMD_NOP;
            3'b110:  cmd = CMD_NOP;   // burst stop: no state effect here
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            default: cmd = CMD_LMR;
         endcase
      end
   end

endmodule

// File: rtl/ddr_chk_banks.sv
`timescale 1ns/1ps
module ddr_chk_banks #(
   parameter int BA_W  = 2,
   parameter int ROW_W = 13,
   localparam int NB   = 1 << BA_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        act_en,
   input  logic                        pre_en,
   input  logic                        pre_all,
   input  logic [BA_W-1:0]             ba,
   input  logic [ROW_W-1:0]            row,
   output logic [NB-1:0]               open_vec,
   output logic [NB-1:0][ROW_W-1:0]    row_tab
);

   for (genvar g = 0; g < NB; g++) begin : g_bank
      logic hit;
      assign hit = (ba == BA_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_vec[g] <= 1'b0;
            row_tab[g]  <= '0;
         end else if (act_en && hit) begin
            open_vec[g] <= 1'b1;
            row_tab[g]  <= row;
         end else if (pre_en && (pre_all || hit)) begin
            open_vec[g] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ddr_chk_timers.sv
`timescale 1ns/1ps
module ddr_chk_timers #(
   parameter int MRD_CYCLES  = 2,
   parameter int LOCK_CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lmr_ok,
   input  logic ext_sel,
   input  logic dll_bit,
   output logic mrd_busy,
   output logic lock_busy
);

   logic dll_off;
   logic dll_turn_on;
   logic dll_turn_off;

   assign dll_turn_on  = lmr_ok && ext_sel && !dll_bit && dll_off;
   assign dll_turn_off = lmr_ok && ext_sel && dll_bit;

   always_ff @(posedge clk) begin
      if (!rst_n)
         dll_off <= 1'b1;
      else if (lmr_ok && ext_sel)
         dll_off <= dll_bit;
   end

   // mode-register settling window
   if (MRD_CYCLES > 1) begin : g_mrd_cnt
      localparam int MRD_W = $clog2(MRD_CYCLES);
      logic [MRD_W-1:0] mrd_cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)
            mrd_cnt <= '0;
         else if (lmr_ok)
            mrd_cnt <= MRD_W'(MRD_CYCLES - 1);
         else if (mrd_cnt != '0)
            mrd_cnt <= mrd_cnt - 1'b1;
      end
      assign mrd_busy = (mrd_cnt != '0);
   end else begin : g_mrd_none
      assign mrd_busy = 1'b0;
   end

   // DLL relock window
   if (LOCK_CYCLES > 1) begin : g_lock_cnt
      localparam int LOCK_W = $clog2(LOCK_CYCLES);
      logic [LOCK_W-1:0] lock_cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)
            lock_cnt <= '0;
         else if (dll_turn_on)
            lock_cnt <= LOCK_W'(LOCK_CYCLES - 1);
         else if (dll_turn_off)
            lock_cnt <= '0;
         else if (lock_cnt != '0)
            lock_cnt <= lock_cnt - 1'b1;
      end
      assign lock_busy = (lock_cnt != '0);
   end else begin : g_lock_none
      assign lock_busy = 1'b0;
   end

endmodule

// File: rtl/ddr_cmd_checker.sv
`timescale 1ns/1ps
module ddr_cmd_checker
   import ddr_chk_pkg::*;
#(
   parameter int BA_W        = 2,
   parameter int ADDR_W      = 13,
   parameter int AP_BIT      = 10,
   parameter int DLL_BIT     = 0,
   parameter int EXT_SEL     = 1,
   parameter int MRD_CYCLES  = 2,
   parameter int LOCK_CYCLES = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BA_W-1:0]   ba,
   input  logic [ADDR_W-1:0] addr,
   output logic              err_valid,
   output logic [2:0]        err_code
);

   localparam int NB = 1 << BA_W;

   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must index into addr");
   end
   if (DLL_BIT >= ADDR_W) begin : g_bad_dll
      $error("DLL_BIT must index into addr");
   end
   if (MRD_CYCLES < 1 || LOCK_CYCLES < 1) begin : g_bad_win
      $error("window lengths must be at least one cycle");
   end
   if (EXT_SEL >= NB) begin : g_bad_ext
      $error("EXT_SEL must be a valid bank value");
   end

   cmd_e                         cmd;
   logic [NB-1:0]                bank_open;
   logic [NB-1:0][ADDR_W-1:0]    bank_row;
   logic                         mrd_busy;
   logic                         lock_busy;
   logic                         any_open;
   logic                         sel_open;
   logic [2:0]                   err_next;
   logic                         accept;

   ddr_chk_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   assign any_open = |bank_open;
   assign sel_open = bank_open[ba];

   always_comb begin
      err_next = ERR_NONE;
      if (mrd_busy && cmd != CMD_DESEL && cmd != CMD_NOP) begin
         err_next = ERR_MRD_WIN;
      end else begin
         unique case (cmd)
            CMD_LMR: if (any_open)  err_next = ERR_LMR_OPEN;
            CMD_REF: if (any_open)  err_next = ERR_REF_OPEN;
            CMD_ACT: if (sel_open)  err_next = ERR_ACT_OPEN;
            CMD_RD: begin
               if (lock_busy)       err_next = ERR_DLL_LOCK;
               else if (!sel_open)  err_next = ERR_IDLE_ACC;
            end
            CMD_WR:  if (!sel_open) err_next = ERR_IDLE_ACC;
            default: err_next = ERR_NONE;
         endcase
      end
   end

   assign accept = (err_next == ERR_NONE);

   ddr_chk_banks #(
      .BA_W  (BA_W),
      .ROW_W (ADDR_W)
   ) u_banks (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_en   (accept && cmd == CMD_ACT),
      .pre_en   (accept && cmd == CMD_PRE),
      .pre_all  (addr[AP_BIT]),
      .ba       (ba),
      .row      (addr),
      .open_vec (bank_open),
      .row_tab  (bank_row)
   );

   ddr_chk_timers #(
      .MRD_CYCLES  (MRD_CYCLES),
      .LOCK_CYCLES (LOCK_CYCLES)
   ) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .lmr_ok    (accept && cmd == CMD_LMR),
      .ext_sel   (ba == BA_W'(EXT_SEL)),
      .dll_bit   (addr[DLL_BIT]),
      .mrd_busy  (mrd_busy),
      .lock_busy (lock_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_valid <= 1'b0;
         err_code  <= ERR_NONE;
      end else begin
         err_valid <= !accept;
         err_code  <= err_next;
      end
   end

endmodule

// File: rtl/ddr_cmd_checker_sva.sv
`timescale 1ns/1ps
module ddr_cmd_checker_sva #(
   parameter int BA_W   = 2,
   parameter int ADDR_W = 13,
   localparam int NB    = 1 << BA_W
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cs_n,
   input logic                     ras_n,
   input logic                     cas_n,
   input logic                     we_n,
   input logic [BA_W-1:0]          ba,
   input logic [ADDR_W-1:0]        addr,
   input logic                     err_valid,
   input logic [2:0]               err_code,
   input logic [NB-1:0]            bank_open,
   input logic [NB-1:0][ADDR_W-1:0] bank_row,
   input logic                     mrd_busy,
   input logic                     lock_busy
);

   logic [2:0] pins;
   logic       real_cmd;
   assign pins     = {ras_n, cas_n, we_n};
   assign real_cmd = !cs_n && !(ras_n && cas_n);

   // R1
   desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !err_valid);

   // R10
   code_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid == (err_code != 3'd0));

   // R3
   mrd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mrd_busy && real_cmd) |=> (err_valid && err_code == 3'd2));

   // R2
   lmr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mrd_busy && !cs_n && pins == 3'b000 && |bank_open) |=> err_code == 3'd1);

   // R5
   dll_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mrd_busy && !cs_n && pins == 3'b101 && lock_busy) |=> err_code == 3'd3);

   // R6
   act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mrd_busy && !cs_n && pins == 3'b011 && bank_open[ba]) |=> err_code == 3'd4);

   // R6
   act_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mrd_busy && !cs_n && pins == 3'b011 && !bank_open[ba])
      |=> (bank_open[$past(ba)] && bank_row[$past(ba)] == $past(addr)));

   // R8
   wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mrd_busy && !cs_n && pins == 3'b100 && !bank_open[ba]) |=> err_code == 3'd5);

   // R9
   ref_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mrd_busy && !cs_n && pins == 3'b001 && |bank_open) |=> err_code == 3'd6);

endmodule

bind ddr_cmd_checker ddr_cmd_checker_sva #(
   .BA_W   (BA_W),
   .ADDR_W (ADDR_W)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba        (ba),
   .addr      (addr),
   .err_valid (err_valid),
   .err_code  (err_code),
   .bank_open (bank_open),
   .bank_row  (bank_row),
   .mrd_busy  (mrd_busy),
   .lock_busy (lock_busy)
);

// File: tb/tb_ddr_cmd_checker.sv
`timescale 1ns/1ps
module tb_ddr_cmd_checker;

   localparam logic [2:0] P_NOP = 3'b111, P_BST = 3'b110, P_ACT = 3'b011,
                          P_RD = 3'b101, P_WR = 3'b100, P_PRE = 3'b010,
                          P_REF = 3'b001, P_LMR = 3'b000;
   localparam int LOCK = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic        err_valid;
   logic [2:0]  err_code;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct { logic [2:0] code; string tag; } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   ddr_cmd_checker dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .addr(addr), .err_valid(err_valid), .err_code(err_code)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // driver: one command per cycle, one expected code per command
   task automatic issue(input logic cs, input logic [2:0] p, input logic [1:0] b,
                        input logic [12:0] a, input logic [2:0] exp, input string tag);
      exp_t it;
      @(negedge clk);
      cs_n = cs; {ras_n, cas_n, we_n} = p; ba = b; addr = a;
      it.code = exp; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic cmd(input logic [2:0] p, input logic [1:0] b, input logic [12:0] a,
                      input logic [2:0] exp, input string tag);
      issue(1'b0, p, b, a, exp, tag);
   endtask

   // monitor: result due one edge after the command
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t it;
         it = sb.pop_front();
         check(err_code == it.code, it.tag, err_code, it.code);
         check(err_valid == (it.code != 3'd0), it.tag, err_valid, it.code != 3'd0);
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(err_valid == 1'b0 && err_code == 3'd0, "R10 reset", err_code, 0);
      rst_n = 1'b1;
      cmd(P_NOP, 2'd0, 13'd0, 3'd0, "R10 idle after reset");
      // R1 no-effect commands
      issue(1'b1, P_LMR, 2'd3, 13'h1fff, 3'd0, "R1 deselect");
      cmd(P_BST, 2'd0, 13'd0, 3'd0, "R1 burst stop");
      // R8 idle bank access
      cmd(P_RD, 2'd0, 13'd0, 3'd5, "R8 read idle");
      cmd(P_WR, 2'd2, 13'd0, 3'd5, "R8 write idle");
      // R6 open / reopen
      cmd(P_ACT, 2'd0, 13'd5, 3'd0, "R6 open b0");
      cmd(P_ACT, 2'd0, 13'd6, 3'd4, "R6 reopen b0");
      cmd(P_WR, 2'd0, 13'd0, 3'd0, "R8 write open");
      cmd(P_RD, 2'd0, 13'd0, 3'd0, "R5 read dll off");
      // R9, R2 with an open row
      cmd(P_REF, 2'd0, 13'd0, 3'd6, "R9 refresh open");
      cmd(P_LMR, 2'd0, 13'd0, 3'd1, "R2 load open");
      cmd(P_ACT, 2'd1, 13'd0, 3'd0, "R3 no window after refused load");
      cmd(P_ACT, 2'd3, 13'd0, 3'd0, "R6 open b3");
      // R7 single and all precharge
      cmd(P_PRE, 2'd1, 13'd0, 3'd0, "R7 pre b1");
      cmd(P_ACT, 2'd1, 13'd9, 3'd0, "R7 b1 closed");
      cmd(P_ACT, 2'd3, 13'd0, 3'd4, "R7 b3 still open");
      cmd(P_PRE, 2'd2, 13'h400, 3'd0, "R7 pre all");
      cmd(P_RD, 2'd0, 13'd0, 3'd5, "R7 b0 closed");
      cmd(P_RD, 2'd3, 13'd0, 3'd5, "R7 b3 closed");
      cmd(P_PRE, 2'd2, 13'd0, 3'd0, "R7 pre idle");
      cmd(P_REF, 2'd0, 13'd0, 3'd0, "R9 refresh idle");
      // R3 mode window
      cmd(P_LMR, 2'd0, 13'h022, 3'd0, "R3 load base");
      cmd(P_ACT, 2'd2, 13'd1, 3'd2, "R3 act in window");
      cmd(P_ACT, 2'd2, 13'd1, 3'd0, "R3 act after window");
      cmd(P_PRE, 2'd0, 13'h400, 3'd0, "R7 pre all");
      // R5 DLL relock
      cmd(P_LMR, 2'd1, 13'd0, 3'd0, "R4 enable dll");
      cmd(P_NOP, 2'd0, 13'd0, 3'd0, "R1 nop in window");
      cmd(P_ACT, 2'd0, 13'd7, 3'd0, "R6 open b0");
      cmd(P_RD, 2'd0, 13'd0, 3'd3, "R5 read early");
      for (int i = 4; i < LOCK - 1; i++) cmd(P_NOP, 2'd0, 13'd0, 3'd0, "R1 wait");
      cmd(P_RD, 2'd0, 13'd0, 3'd3, "R5 read one short");
      cmd(P_RD, 2'd0, 13'd0, 3'd0, "R5 read at lock");
      // R4 disable, base load does not enable
      cmd(P_PRE, 2'd0, 13'h400, 3'd0, "R7 pre all");
      cmd(P_LMR, 2'd1, 13'd1, 3'd0, "R4 disable dll");
      cmd(P_NOP, 2'd0, 13'd0, 3'd0, "R1 nop");
      cmd(P_LMR, 2'd0, 13'd0, 3'd0, "R4 base load");
      cmd(P_NOP, 2'd0, 13'd0, 3'd0, "R1 nop");
      cmd(P_ACT, 2'd0, 13'd3, 3'd0, "R6 open b0");
      cmd(P_RD, 2'd0, 13'd0, 3'd0, "R4 base load left dll off");
      // R4 drive bit ignored, relock restarts
      cmd(P_PRE, 2'd0, 13'h400, 3'd0, "R7 pre all");
      cmd(P_LMR, 2'd1, 13'd2, 3'd0, "R4 enable reduced drive");
      cmd(P_NOP, 2'd0, 13'd0, 3'd0, "R1 nop");
      cmd(P_ACT, 2'd0, 13'd3, 3'd0, "R6 open b0");
      cmd(P_RD, 2'd0, 13'd0, 3'd3, "R5 relock restarted");
      cmd(P_NOP, 2'd0, 13'd0, 3'd0, "R1 tail");
      @(posedge clk); #3;
      @(posedge clk); #3;
      check(sb.size() == 0, "R10 scoreboard drained", sb.size(), 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule